// File: doc/BRIEF.md
# Text-Mode Vertical Scan Address Generator

This block is the vertical half of a legacy-compatible CRT controller. It steps once per horizontal scan line and keeps three counters. The first counts scan lines from the top of the frame. The second counts the scan lines inside the current character row. The third holds the frame-buffer address at which the current text row starts. It also drives a registered vertical blanking flag. Horizontal timing, sync generation, pixel fetch and register decoding live elsewhere; every programmed field arrives as a plain input port.

Each text row is `max_row + 1` scan lines tall. At the end of a row, the row start address moves forward by a programmed byte pitch. In double-scan mode the row counter advances only on every second line, so each source line is shown twice. A 10-bit line-compare value splits the screen. From the compared line downwards, fetching restarts at address zero. The blanking-start line number is 10 bits wide in standard mode and 12 bits wide in extended mode.

Top module: `vscan_addr_gen`

## Requirements
- R1: After reset, `row_scan` is 0, `line_addr` is 0 and `vblank` is 0.
- R2: A `frame_stb` cycle has priority over `line_stb` and sets the following state, visible on the next cycle:
  - the line count, `row_scan` and the double-scan phase become 0;
  - `line_addr` becomes `{start_hi,start_lo}`, or 0 when the line-compare value is 0;
  - `vblank` becomes 1 exactly when the blanking-start value is 0.
- R3: With `dbl_scan_en`=0, each `line_stb` advances `row_scan` by one. After `row_scan` equals `max_row`, the next advance takes it to 0.
- R4: With `dbl_scan_en`=1, `row_scan` advances only on every second `line_stb` counted from frame start or from a line-compare restart. The first such strobe leaves it unchanged.
- R5: Each time `row_scan` wraps to 0, `line_addr` increases by `row_offset`, modulo 2^16. It does not change on other advances.
- R6: The line-compare value is `{lcmp_b9,lcmp_b8,lcmp_lo}`, with `lcmp_b9` as bit 9. When a `line_stb` moves the line count onto this value, `line_addr` and `row_scan` become 0 and the double-scan phase restarts. Later rows then advance from address 0.
- R7: When the line-compare value is never reached in a frame, addressing runs from the start address without any restart.
- R8: With `ext_mode`=0, the blanking start is `{vbs_b9,vbs_b8,vbs_lo}`, with `vbs_b9` as bit 9, and `vbs_ext` is ignored.
- R9: With `ext_mode`=1, the blanking start is `{vbs_ext,vbs_lo}`, with `vbs_ext` as bits 11:8, and `vbs_b9`/`vbs_b8` are ignored.
- R10: `vblank` rises in the cycle after the `line_stb` that moves the line count onto the blanking start. It then stays 1 until the next `frame_stb`.
- R11: In a cycle with neither strobe, `row_scan`, `line_addr` and `vblank` hold, even if programmed fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Frame-start pulse |
| line_stb | input | 1 | One pulse per completed horizontal scan line |
| dbl_scan_en | input | 1 | Advance the row counter on every second line |
| ext_mode | input | 1 | Select the 12-bit blanking-start width |
| max_row | input | 5 | Scan lines per text row minus one |
| lcmp_b9 | input | 1 | Line-compare bit 9 |
| lcmp_b8 | input | 1 | Line-compare bit 8 |
| lcmp_lo | input | 8 | Line-compare bits 7:0 |
| vbs_b9 | input | 1 | Standard-mode blanking-start bit 9 |
| vbs_b8 | input | 1 | Standard-mode blanking-start bit 8 |
| vbs_ext | input | 4 | Extended-mode blanking-start bits 11:8 |
| vbs_lo | input | 8 | Blanking-start bits 7:0 |
| start_hi | input | 8 | Start address high byte |
| start_lo | input | 8 | Start address low byte |
| row_offset | input | 16 | Byte pitch added per text row |
| row_scan | output | 5 | Current scan line within the text row |
| line_addr | output | 16 | Frame-buffer address of the current row start |
| vblank | output | 1 | Registered vertical blanking flag |

## Verification
Single-scan frames with the compare point beyond the last line show that the row counter wraps and that the pitch accumulates without any restart. Moving the compare point to mid-screen shows the jump to address zero and the reset of the row count there. Double-scan frames show the halved advance rate, both from frame start and after a split. One field set is applied in both blanking modes, with the two modes decoding to different line numbers, so the flag shows which high bits were taken. Random frames with all fields drawn at random, a blanking start of zero, simultaneous strobes and idle cycles with changing fields cover the remaining orderings.

// File: rtl/vscan_addr_gen.sv
module vscan_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 12,
  parameter int ROW_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              line_stb,
  input  logic              dbl_scan_en,
  input  logic              ext_mode,
  input  logic [ROW_W-1:0]  max_row,
  input  logic              lcmp_b9,
  input  logic              lcmp_b8,
  input  logic [7:0]        lcmp_lo,
  input  logic              vbs_b9,
  input  logic              vbs_b8,
  input  logic [3:0]        vbs_ext,
  input  logic [7:0]        vbs_lo,
  input  logic [7:0]        start_hi,
  input  logic [7:0]        start_lo,
  input  logic [ADDR_W-1:0] row_offset,
  output logic [ROW_W-1:0]  row_scan,
  output logic [ADDR_W-1:0] line_addr,
  output logic              vblank
);

  logic [LINE_W-1:0] line_cnt;
  logic              dbl_phase;

  wire [LINE_W-1:0] lcmp_val  = LINE_W'({lcmp_b9, lcmp_b8, lcmp_lo});
  wire [LINE_W-1:0] vbs_std   = LINE_W'({vbs_b9, vbs_b8, vbs_lo});
  wire [LINE_W-1:0] vbs_xt    = LINE_W'({vbs_ext, vbs_lo});
  wire [LINE_W-1:0] vbs_val   = ext_mode ? vbs_xt : vbs_std;
  wire [ADDR_W-1:0] start_adr = ADDR_W'({start_hi, start_lo});

  wire [LINE_W-1:0] next_line = line_cnt + 1'b1;
  wire              hit_cmp   = (next_line == lcmp_val);
  wire              hit_blank = (next_line == vbs_val);
  wire              advance   = !dbl_scan_en || dbl_phase;
  wire              row_end   = (row_scan == max_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      dbl_phase <= 1'b0;
      row_scan  <= '0;
      line_addr <= '0;
      vblank    <= 1'b0;
    end else if (frame_stb) begin
      line_cnt  <= '0;
      dbl_phase <= 1'b0;
      row_scan  <= '0;
      line_addr <= (lcmp_val == '0) ? '0 : start_adr;
      vblank    <= (vbs_val == '0);
    end else if (line_stb) begin
      line_cnt <= next_line;
      vblank   <= vblank | hit_blank;
      if (hit_cmp) begin
        dbl_phase <= 1'b0;
        row_scan  <= '0;
        line_addr <= '0;
      end else begin
        dbl_phase <= dbl_scan_en ? !dbl_phase : 1'b0;
        if (advance) begin
          if (row_end) begin
            row_scan  <= '0;
            line_addr <= line_addr + row_offset;
          end else begin
            row_scan <= row_scan + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/vscan_addr_gen_chk.sv
module vscan_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 12,
  parameter int ROW_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              line_stb,
  input logic              dbl_scan_en,
  input logic [ROW_W-1:0]  max_row,
  input logic              lcmp_b9,
  input logic              lcmp_b8,
  input logic [7:0]        lcmp_lo,
  input logic [7:0]        start_hi,
  input logic [7:0]        start_lo,
  input logic [LINE_W-1:0] line_cnt,
  input logic [ROW_W-1:0]  row_scan,
  input logic [ADDR_W-1:0] line_addr,
  input logic              vblank
);

  wire [LINE_W-1:0] cmp_pt = LINE_W'({lcmp_b9, lcmp_b8, lcmp_lo});
  wire [LINE_W-1:0] nl     = line_cnt + 1'b1;

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && (cmp_pt != '0) |=> (row_scan == '0) &&
      (line_addr == ADDR_W'($past({start_hi, start_lo}))) && (line_cnt == '0)); // R2

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && !frame_stb && !dbl_scan_en && (row_scan == max_row) |=> row_scan == '0); // R3

  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && !frame_stb && (nl == cmp_pt) |=> (line_addr == '0) && (row_scan == '0)); // R6

  AST_BLANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && !frame_stb |=> vblank); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb && !frame_stb |=> $stable(row_scan) && $stable(line_addr) && $stable(vblank)); // R11

endmodule

bind vscan_addr_gen vscan_addr_gen_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .ROW_W(ROW_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
  .dbl_scan_en(dbl_scan_en), .max_row(max_row), .lcmp_b9(lcmp_b9),
  .lcmp_b8(lcmp_b8), .lcmp_lo(lcmp_lo), .start_hi(start_hi),
  .start_lo(start_lo), .line_cnt(line_cnt), .row_scan(row_scan),
  .line_addr(line_addr), .vblank(vblank)
);

// File: tb/vscan_addr_gen_tb_top.sv
`timescale 1ns/1ps
module vscan_addr_gen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 0, line_stb = 0, dbl_scan_en = 0, ext_mode = 0;
  logic [4:0] max_row = 0;
  logic lcmp_b9 = 1, lcmp_b8 = 1;
  logic [7:0] lcmp_lo = 8'hff;
  logic vbs_b9 = 1, vbs_b8 = 1;
  logic [3:0] vbs_ext = 4'hf;
  logic [7:0] vbs_lo = 8'hff, start_hi = 0, start_lo = 0;
  logic [15:0] row_offset = 0;
  logic [4:0] row_scan;
  logic [15:0] line_addr;
  logic vblank;

  int checks = 0, errors = 0;
  logic [11:0] m_line = 0;
  logic [4:0]  m_row = 0;
  logic [15:0] m_addr = 0;
  logic        m_ph = 0, m_blank = 0;

  always #2.5 clk = ~clk;

  vscan_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
    .dbl_scan_en(dbl_scan_en), .ext_mode(ext_mode), .max_row(max_row),
    .lcmp_b9(lcmp_b9), .lcmp_b8(lcmp_b8), .lcmp_lo(lcmp_lo),
    .vbs_b9(vbs_b9), .vbs_b8(vbs_b8), .vbs_ext(vbs_ext), .vbs_lo(vbs_lo),
    .start_hi(start_hi), .start_lo(start_lo), .row_offset(row_offset),
    .row_scan(row_scan), .line_addr(line_addr), .vblank(vblank)
  );

  function automatic logic [11:0] cmp_pt();
    return {2'b00, lcmp_b9, lcmp_b8, lcmp_lo};
  endfunction

  function automatic logic [11:0] blank_pt();
    return ext_mode ? {vbs_ext, vbs_lo} : {2'b00, vbs_b9, vbs_b8, vbs_lo};
  endfunction

  task automatic model(input bit fr, input bit ln);
    logic [11:0] nl;
    logic adv;
    if (fr) begin
      m_line = 0; m_row = 0; m_ph = 0;
      m_addr = (cmp_pt() == 0) ? 16'h0 : {start_hi, start_lo};
      m_blank = (blank_pt() == 0);
    end else if (ln) begin
      nl = m_line + 1'b1;
      adv = !dbl_scan_en || m_ph;
      m_ph = dbl_scan_en ? !m_ph : 1'b0;
      if (nl == blank_pt()) m_blank = 1'b1;
      if (nl == cmp_pt()) begin
        m_row = 0; m_addr = 0; m_ph = 0;
      end else if (adv) begin
        if (m_row == max_row) begin
          m_row = 0; m_addr = m_addr + row_offset;
        end else m_row = m_row + 1'b1;
      end
      m_line = nl;
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d)", tag, what, act, exp, m_line);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "row_scan", int'(row_scan), int'(m_row));
    check(tag, "line_addr", int'(line_addr), int'(m_addr));
    check(tag, "vblank", int'(vblank), int'(m_blank));
  endtask

  task automatic step(input bit fr, input bit ln, input string tag);
    @(negedge clk);
    frame_stb = fr; line_stb = ln;
    model(fr, ln);
    @(negedge clk);
    frame_stb = 0; line_stb = 0;
    compare(tag);
  endtask

  task automatic run_lines(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, tag);
  endtask

  task automatic setup(input bit dbl, input bit ext, input logic [4:0] mr,
                       input logic [9:0] lc, input logic [11:0] vb,
                       input logic [15:0] st, input logic [15:0] off);
    dbl_scan_en = dbl; ext_mode = ext; max_row = mr;
    {lcmp_b9, lcmp_b8, lcmp_lo} = lc;
    vbs_lo = vb[7:0]; vbs_ext = vb[11:8]; {vbs_b9, vbs_b8} = vb[9:8];
    {start_hi, start_lo} = st; row_offset = off;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd815));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3 R5 R7 R8: single scan, no split, standard blanking at 400
    setup(0, 0, 5'd15, 10'd1023, 12'd400, 16'h1234, 16'd80);
    step(1, 0, "R2");
    run_lines(300, "R3");
    run_lines(150, "R7");
    run_lines(20, "R10");

    // R6: split in mid-screen
    setup(0, 0, 5'd15, 10'd100, 12'd300, 16'h4000, 16'd160);
    step(1, 0, "R2");
    run_lines(320, "R6");

    // R4: double scan, plain and with split
    setup(1, 0, 5'd7, 10'd1023, 12'd200, 16'h0100, 16'd40);
    step(1, 0, "R2");
    run_lines(220, "R4");
    setup(1, 0, 5'd3, 10'd51, 12'd900, 16'h0200, 16'd40);
    step(1, 0, "R2");
    run_lines(120, "R4");

    // R9: extended gives 0x110 (272); standard view of same bits is 0x210 (528)
    setup(0, 1, 5'd7, 10'd1023, 12'h110, 16'h0000, 16'd100);
    vbs_b9 = 1; vbs_b8 = 0;
    step(1, 0, "R2");
    run_lines(300, "R9");
    // R8: standard width with the same low byte, ext field nonzero
    ext_mode = 0;
    step(1, 0, "R2");
    run_lines(540, "R8");

    // R5: address wrap modulo 2^16
    setup(0, 0, 5'd1, 10'd1023, 12'd900, 16'hfff0, 16'h0009);
    step(1, 0, "R2");
    run_lines(10, "R5");

    // R2: blank start zero, split at zero, simultaneous strobes
    setup(0, 0, 5'd2, 10'd0, 12'd0, 16'h5555, 16'd7);
    step(1, 0, "R2");
    run_lines(12, "R10");
    setup(0, 0, 5'd2, 10'd1023, 12'd600, 16'h5555, 16'd7);
    run_lines(5, "R3");
    step(1, 1, "R2");

    // R11: idle cycles with fields changing
    run_lines(7, "R3");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start_hi = 8'($urandom); row_offset = 16'($urandom);
      max_row = 5'($urandom); vbs_lo = 8'd0; lcmp_lo = 8'd0;
      compare("R11");
    end

    // Random frames
    for (int f = 0; f < 10; f++) begin
      setup(1'($urandom), 1'($urandom), 5'($urandom),
            10'($urandom_range(0, 1023)), 12'($urandom_range(0, 700)),
            16'($urandom), 16'($urandom_range(0, 300)));
      {vbs_b9, vbs_b8} = 2'($urandom);
      step(1, 0, "R2");
      run_lines($urandom_range(50, 650), "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule